// File: doc/BRIEF.md
# GPIO Configuration Register Bank

This block is the register file of a general-purpose I/O controller with a parameterised number of pins. The default is 94. Software reaches it through a simple word-wide read/write port that takes byte offsets. The state it holds comes in two shapes.

The first shape is the bitmapped banks. These are the ownership map, the interrupt status and the interrupt enable. Each holds one bit per pin, packed 32 pins to a word.

The second shape is the per-pin records. Every pin has a record of two words. The record holds the drive level, direction, GPIO/native selection, trigger kind, trigger sense inversion, weak-pull code and input-sense disable. The record also exposes the pin's synchronised input level.

Towards the pins, the block drives the output level, the output enable, the mode select, the pull code, the sense enable and the trigger configuration. A separate interrupt detector consumes the trigger configuration and reports detected events back on a set strobe. That strobe raises status bits, and software clears them by writing ones. A single routing bit selects which parent interrupt line the controller uses.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every pin is an input in native mode with sensing off, so its first record word reads 0x00000004 and its second record word reads 0x00000004. pin_oe, pin_gpio and pin_sense_en are all zero. The ownership bitmap reads back the OWN_INIT parameter, whose default is all ones except pins 1 and 3.
- R2: For pin p, a bitmapped bank word sits at bank base + (p/32)*4 and the pin's bit is p mod 32. The bank bases are: ownership 0x000, status 0x080, enable 0x090. Word bits above the last pin read 0, and so do words past the last pin's word.
- R3: Pin p's first record word is at 0x100 + 8p and its second record word is at 0x104 + 8p. Address bits 1:0 are ignored.
- R4: In the first record word, the fields are: bit 31 drive level, bit 30 input level, bit 4 trigger kind (1 = level, 0 = edge), bit 3 trigger inversion, bit 2 direction (1 = input), bit 0 mode (1 = GPIO). All other bits read 0, and writes to them are dropped.
- R5: Bit 30 is read-only. While sensing is enabled, it follows pin_in three clock edges after a change. While sensing is disabled, it holds its last value.
- R6: In the second record word, bit 2 disables sensing and bits 1:0 are the pull code. pin_sense_en is the inverse of bit 2, and pin_pull[2p+1:2p] carries the pull code.
- R7: pin_oe of a pin is 1 exactly when its mode bit is 1 and its direction bit is 0. pin_out follows bit 31. A change of pin_oe only follows a bus write.
- R8: Offsets that map to nothing, including record slots at or past pin NUM_PINS, read 0, and writes to them change no state.
- R9: A pulse on irq_set sets the pin's status bit on the next edge. Writing a 1 to a status bit clears it, and writing 0 leaves it alone. If a set and a clear reach the same bit on the same edge, the set wins.
- R10: Enable bits are read/write and drive irq_enable. trig_level and trig_invert carry bits 4 and 3 of each record.
- R11: Offset 0x07C holds a single routing bit at bit 0, which drives irq_route. Its other bits read 0.
- R12: rdata is loaded on the rising edge where rd_en is high, and it holds its value on every edge where rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Raw pin input levels |
| irq_set | input | NUM_PINS | Event strobes from the interrupt detector |
| pin_out | output | NUM_PINS | Drive level per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |
| pin_gpio | output | NUM_PINS | 1 = GPIO mode, 0 = native function |
| pin_pull | output | 2*NUM_PINS | Weak-pull code, two bits per pin |
| pin_sense_en | output | NUM_PINS | Input sensing enable per pin |
| trig_level | output | NUM_PINS | Trigger kind per pin (1 = level) |
| trig_invert | output | NUM_PINS | Trigger sense inversion per pin |
| irq_enable | output | NUM_PINS | Interrupt enable per pin |
| irq_route | output | 1 | Parent interrupt line select |

## Verification
Each result has its own due time:
- Writes take effect on the edge that samples wr_en, so pin-side outputs are compared at the following falling edge.
- Read data is loaded on the edge that samples rd_en and is compared at the falling edge after that.
- The input level needs three edges (two synchroniser stages, then the held level register). The bench therefore waits four falling edges after changing pin_in before it issues the read.
- A status bit rises one edge after its irq_set pulse. The bench reads it back only after the pulse has been removed, so only the stored state is being observed.

// File: rtl/gpio_regbank_pkg.sv
package gpio_regbank_pkg;

    localparam logic [31:0] OFS_OWN   = 32'h000;
    localparam logic [31:0] OFS_ROUTE = 32'h07C;
    localparam logic [31:0] OFS_STAT  = 32'h080;
    localparam logic [31:0] OFS_IEN   = 32'h090;
    localparam logic [31:0] OFS_CFG   = 32'h100;

    // field positions in the first record word
    localparam int B_OUT  = 31;
    localparam int B_IN   = 30;
    localparam int B_TRIG = 4;
    localparam int B_INV  = 3;
    localparam int B_DIR  = 2;
    localparam int B_USE  = 0;
    // field positions in the second record word
    localparam int B_DIS  = 2;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_OWN,
        RGN_ROUTE,
        RGN_STAT,
        RGN_IEN,
        RGN_CFG1,
        RGN_CFG2
    } region_e;

    typedef struct packed {
        logic       out_lvl;
        logic       trig_lvl;
        logic       trig_inv;
        logic       dir_in;
        logic       use_gpio;
        logic       sense_dis;
        logic [1:0] pull;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{out_lvl: 1'b0, trig_lvl: 1'b0, trig_inv: 1'b0,
                                       dir_in: 1'b1, use_gpio: 1'b0, sense_dis: 1'b1,
                                       pull: 2'b00};

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regbank_pkg::*;
#(
    parameter int NUM_PINS   = 94,
    parameter int ADDR_W     = 12,
    parameter int NUM_WORDS  = 3,
    parameter int PIN_IDX_W  = 7,
    parameter int WORD_IDX_W = 2
) (
    input  logic [ADDR_W-1:0]     addr,
    output region_e               region,
    output logic [PIN_IDX_W-1:0]  pin_idx,
    output logic [WORD_IDX_W-1:0] word_idx
);

    localparam logic [31:0] BANK_SPAN = 32'(NUM_WORDS * 4);

    logic [31:0] a_word;
    logic [31:0] cfg_off;
    logic [31:0] pin_num;
    logic [31:0] bank_word;

    // unsigned wrap makes an address below the base fall outside the span
    function automatic logic in_bank(input logic [31:0] x, input logic [31:0] base);
        return (x - base) < BANK_SPAN;
    endfunction

    always_comb begin
        a_word    = 32'(addr) & 32'hFFFF_FFFC;
        cfg_off   = a_word - OFS_CFG;
        pin_num   = cfg_off >> 3;
        bank_word = 32'd0;
        region    = RGN_NONE;
        if (!in_bank(a_word, OFS_OWN) && a_word >= OFS_CFG) begin
            if (pin_num < 32'(NUM_PINS))
                region = cfg_off[2] ? RGN_CFG2 : RGN_CFG1;
        end else if (a_word == OFS_ROUTE) begin
            region = RGN_ROUTE;
        end else if (in_bank(a_word, OFS_OWN)) begin
            region    = RGN_OWN;
            bank_word = (a_word - OFS_OWN) >> 2;
        end else if (in_bank(a_word, OFS_STAT)) begin
            region    = RGN_STAT;
            bank_word = (a_word - OFS_STAT) >> 2;
        end else if (in_bank(a_word, OFS_IEN)) begin
            region    = RGN_IEN;
            bank_word = (a_word - OFS_IEN) >> 2;
        end
        pin_idx  = PIN_IDX_W'(pin_num);
        word_idx = WORD_IDX_W'(bank_word);
    end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
    import gpio_regbank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_cfg1,
    input  logic     wr_cfg2,
    input  pin_cfg_t wr_val,
    input  logic     pin_in,
    output pin_cfg_t cfg_q,
    output logic     in_lvl_q
);

    logic [1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (wr_cfg1) begin
                cfg_q.out_lvl  <= wr_val.out_lvl;
                cfg_q.trig_lvl <= wr_val.trig_lvl;
                cfg_q.trig_inv <= wr_val.trig_inv;
                cfg_q.dir_in   <= wr_val.dir_in;
                cfg_q.use_gpio <= wr_val.use_gpio;
            end
            if (wr_cfg2) begin
                cfg_q.sense_dis <= wr_val.sense_dis;
                cfg_q.pull      <= wr_val.pull;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= 2'b00;
            in_lvl_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_in};
            if (!cfg_q.sense_dis)
                in_lvl_q <= sync_q[1];
        end
    end

    // R5
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_q.sense_dis) |-> $stable(in_lvl_q));

endmodule

// File: rtl/gpio_bitmap_bank.sv
module gpio_bitmap_bank #(
    parameter int                  NUM_PINS   = 94,
    parameter int                  NUM_WORDS  = 3,
    parameter int                  WORD_IDX_W = 2,
    parameter logic [NUM_PINS-1:0] OWN_INIT   = '1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_own,
    input  logic                  wr_stat,
    input  logic                  wr_ien,
    input  logic [WORD_IDX_W-1:0] word_idx,
    input  logic [31:0]           wdata,
    input  logic [NUM_PINS-1:0]   irq_set,
    output logic [NUM_PINS-1:0]   own_q,
    output logic [NUM_PINS-1:0]   stat_q,
    output logic [NUM_PINS-1:0]   ien_q
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        localparam int WORD = i / 32;
        localparam int BIT  = i % 32;

        logic hit;
        assign hit = (word_idx == WORD_IDX_W'(WORD)) && wdata[BIT];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                own_q[i]  <= OWN_INIT[i];
                stat_q[i] <= 1'b0;
                ien_q[i]  <= 1'b0;
            end else begin
                if (wr_own && word_idx == WORD_IDX_W'(WORD))
                    own_q[i] <= wdata[BIT];
                if (wr_ien && word_idx == WORD_IDX_W'(WORD))
                    ien_q[i] <= wdata[BIT];
                stat_q[i] <= irq_set[i] | (stat_q[i] & ~(wr_stat & hit));
            end
        end

        // R9
        stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_set[i] |=> stat_q[i]);

        // R9
        stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(stat_q[i]) && !stat_q[i]) |-> $past(wr_stat));
    end

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_regbank_pkg::*;
#(
    parameter int                  NUM_PINS = 94,
    parameter int                  ADDR_W   = 12,
    parameter logic [NUM_PINS-1:0] OWN_INIT = {{(NUM_PINS-4){1'b1}}, 4'b0101}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic [NUM_PINS-1:0]   irq_set,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [NUM_PINS-1:0]   pin_gpio,
    output logic [2*NUM_PINS-1:0] pin_pull,
    output logic [NUM_PINS-1:0]   pin_sense_en,
    output logic [NUM_PINS-1:0]   trig_level,
    output logic [NUM_PINS-1:0]   trig_invert,
    output logic [NUM_PINS-1:0]   irq_enable,
    output logic                  irq_route
);

    localparam int NUM_WORDS  = (NUM_PINS + 31) / 32;
    localparam int PIN_IDX_W  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int WORD_IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PAD_W      = NUM_WORDS * 32;

    region_e               region;
    logic [PIN_IDX_W-1:0]  pin_idx;
    logic [WORD_IDX_W-1:0] word_idx;

    gpio_addr_decode #(
        .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
        .PIN_IDX_W(PIN_IDX_W), .WORD_IDX_W(WORD_IDX_W)
    ) u_decode (
        .addr(addr), .region(region), .pin_idx(pin_idx), .word_idx(word_idx)
    );

    pin_cfg_t wr_val;
    assign wr_val = '{out_lvl: wdata[B_OUT], trig_lvl: wdata[B_TRIG], trig_inv: wdata[B_INV],
                      dir_in: wdata[B_DIR], use_gpio: wdata[B_USE], sense_dis: wdata[B_DIS],
                      pull: wdata[1:0]};

    pin_cfg_t              cfg_arr [NUM_PINS];
    logic [NUM_PINS-1:0]   in_lvl_v;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic sel;
        assign sel = wr_en && (pin_idx == PIN_IDX_W'(i));

        gpio_pin_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cfg1  (sel && region == RGN_CFG1),
            .wr_cfg2  (sel && region == RGN_CFG2),
            .wr_val   (wr_val),
            .pin_in   (pin_in[i]),
            .cfg_q    (cfg_arr[i]),
            .in_lvl_q (in_lvl_v[i])
        );

        assign pin_out[i]          = cfg_arr[i].out_lvl;
        assign pin_oe[i]           = cfg_arr[i].use_gpio & ~cfg_arr[i].dir_in;
        assign pin_gpio[i]         = cfg_arr[i].use_gpio;
        assign pin_pull[2*i +: 2]  = cfg_arr[i].pull;
        assign pin_sense_en[i]     = ~cfg_arr[i].sense_dis;
        assign trig_level[i]       = cfg_arr[i].trig_lvl;
        assign trig_invert[i]      = cfg_arr[i].trig_inv;
    end

    logic [NUM_PINS-1:0] own_q, stat_q, ien_q;

    gpio_bitmap_bank #(
        .NUM_PINS(NUM_PINS), .NUM_WORDS(NUM_WORDS),
        .WORD_IDX_W(WORD_IDX_W), .OWN_INIT(OWN_INIT)
    ) u_bitmap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_own   (wr_en && region == RGN_OWN),
        .wr_stat  (wr_en && region == RGN_STAT),
        .wr_ien   (wr_en && region == RGN_IEN),
        .word_idx (word_idx),
        .wdata    (wdata),
        .irq_set  (irq_set),
        .own_q    (own_q),
        .stat_q   (stat_q),
        .ien_q    (ien_q)
    );

    assign irq_enable = ien_q;

    logic route_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            route_q <= 1'b0;
        else if (wr_en && region == RGN_ROUTE)
            route_q <= wdata[0];
    end
    assign irq_route = route_q;

    logic [PAD_W-1:0] own_pad, stat_pad, ien_pad;
    assign own_pad  = PAD_W'(own_q);
    assign stat_pad = PAD_W'(stat_q);
    assign ien_pad  = PAD_W'(ien_q);

    pin_cfg_t    sel_cfg;
    logic        sel_in;
    logic [31:0] rd_word;

    always_comb begin
        sel_cfg = CFG_RESET;
        sel_in  = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pin_idx == PIN_IDX_W'(i)) begin
                sel_cfg = cfg_arr[i];
                sel_in  = in_lvl_v[i];
            end
        end
        unique case (region)
            RGN_OWN:   rd_word = own_pad[{word_idx, 5'b0} +: 32];
            RGN_STAT:  rd_word = stat_pad[{word_idx, 5'b0} +: 32];
            RGN_IEN:   rd_word = ien_pad[{word_idx, 5'b0} +: 32];
            RGN_ROUTE: rd_word = {31'd0, route_q};
            RGN_CFG1:  rd_word = {sel_cfg.out_lvl, sel_in, 25'd0, sel_cfg.trig_lvl,
                                  sel_cfg.trig_inv, sel_cfg.dir_in, 1'b0, sel_cfg.use_gpio};
            RGN_CFG2:  rd_word = {29'd0, sel_cfg.sense_dis, sel_cfg.pull};
            default:   rd_word = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= 32'd0;
        else if (rd_en)
            rdata <= rd_word;
    end

    // R7
    oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(wr_en));

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));

endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;

    localparam int NP = 94;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0, irq_set = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_gpio, pin_sense_en, trig_level, trig_invert, irq_enable;
    logic [2*NP-1:0] pin_pull;
    logic          irq_route;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .irq_set(irq_set),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_gpio(pin_gpio), .pin_pull(pin_pull),
        .pin_sense_en(pin_sense_en), .trig_level(trig_level), .trig_invert(trig_invert),
        .irq_enable(irq_enable), .irq_route(irq_route)
    );

    // {write, requirement, offset, data, expected}
    localparam int NV = 23;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 4'd1,  12'h000, 32'h0,        32'hFFFF_FFF5}, // R1 ownership reset
        {1'b0, 4'd2,  12'h008, 32'h0,        32'h3FFF_FFFF}, // R2 top bits zero
        {1'b0, 4'd1,  12'h100, 32'h0,        32'h0000_0004}, // R1
        {1'b0, 4'd1,  12'h104, 32'h0,        32'h0000_0004}, // R1
        {1'b1, 4'd3,  12'h128, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd4,  12'h128, 32'h0,        32'h8000_001D}, // R4 R3
        {1'b1, 4'd6,  12'h12C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd6,  12'h12C, 32'h0,        32'h0000_0007}, // R6
        {1'b1, 4'd10, 12'h094, 32'h0000_00F0, 32'h0},
        {1'b0, 4'd10, 12'h094, 32'h0,        32'h0000_00F0}, // R10
        {1'b1, 4'd2,  12'h098, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd2,  12'h098, 32'h0,        32'h3FFF_FFFF}, // R2
        {1'b1, 4'd11, 12'h07C, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd11, 12'h07C, 32'h0,        32'h0000_0001}, // R11
        {1'b1, 4'd8,  12'h0A0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd8,  12'h0A0, 32'h0,        32'h0},          // R8
        {1'b1, 4'd8,  12'h3F0, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 4'd8,  12'h3F0, 32'h0,        32'h0},          // R8 past last pin
        {1'b0, 4'd8,  12'h3E8, 32'h0,        32'h0000_0004}, // R8 last pin untouched
        {1'b1, 4'd2,  12'h004, 32'h1234_5678, 32'h0},
        {1'b0, 4'd2,  12'h004, 32'h0,        32'h1234_5678}, // R2
        {1'b0, 4'd2,  12'h00C, 32'h0,        32'h0},          // R2 word past last
        {1'b0, 4'd10, 12'h090, 32'h0,        32'h0}           // R10 other word untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state at the pins
        check("R1", 32'(pin_oe != '0), 32'd0);
        check("R1", 32'(pin_gpio != '0), 32'd0);
        check("R1", 32'(pin_sense_en != '0), 32'd0);

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][80]) begin
                bus_write(VEC[v][75:64], VEC[v][63:32]);
            end else begin
                bus_read(VEC[v][75:64], rd);
                checks++;
                if (rd !== VEC[v][31:0]) begin
                    errors++;
                    $display("FAIL R%0d: entry %0d actual %h expected %h",
                             VEC[v][79:76], v, rd, VEC[v][31:0]);
                end
            end
        end

        // R10 R6 R11 pin-side view of the table writes
        check("R10", 32'(trig_level[5]), 32'd1);
        check("R10", 32'(trig_invert[5]), 32'd1);
        check("R10", 32'(irq_enable[39:36]), 32'hF);
        check("R10", 32'(irq_enable[35:32]), 32'h0);
        check("R6", 32'(pin_pull[11:10]), 32'd3);
        check("R6", 32'(pin_sense_en[5]), 32'd0);
        check("R11", 32'(irq_route), 32'd1);

        // R7 output enable needs GPIO mode and output direction
        check("R7", 32'(pin_oe[5]), 32'd0);
        bus_write(12'h128, 32'h8000_0001);
        check("R7", 32'(pin_oe[5]), 32'd1);
        check("R7", 32'(pin_out[5]), 32'd1);
        bus_write(12'h128, 32'h8000_0000);
        check("R7", 32'(pin_oe[5]), 32'd0);
        bus_write(12'h128, 32'h0000_0005);
        check("R7", 32'(pin_oe[5]), 32'd0);
        check("R7", 32'(pin_out[5]), 32'd0);

        // R5 input level sensing on pin 7
        @(negedge clk); pin_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(12'h138, rd);
        check("R5", rd, 32'h0000_0004);
        bus_write(12'h13C, 32'h0);
        check("R6", 32'(pin_sense_en[7]), 32'd1);
        repeat (4) @(negedge clk);
        bus_read(12'h138, rd);
        check("R5", rd, 32'h4000_0004);
        bus_write(12'h138, 32'h0);
        bus_read(12'h138, rd);
        check("R5", rd, 32'h4000_0000);
        bus_write(12'h13C, 32'h4);
        pin_in[7] = 1'b0;
        repeat (5) @(negedge clk);
        bus_read(12'h138, rd);
        check("R5", rd, 32'h4000_0000);

        // R9 status set, write-one clear, set wins
        @(negedge clk); irq_set[3] = 1'b1; irq_set[40] = 1'b1;
        @(negedge clk); irq_set = '0;
        bus_read(12'h080, rd);
        check("R9", rd, 32'h0000_0008);
        bus_read(12'h084, rd);
        check("R9", rd, 32'h0000_0100);
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h080; wdata = 32'h8; irq_set[3] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; irq_set = '0;
        bus_read(12'h080, rd);
        check("R9", rd, 32'h0000_0008);
        bus_write(12'h080, 32'h8);
        bus_read(12'h080, rd);
        check("R9", rd, 32'h0);
        bus_write(12'h084, 32'hFF);
        bus_read(12'h084, rd);
        check("R9", rd, 32'h0000_0100);

        // R12 rdata holds without a read strobe
        held = rdata;
        @(negedge clk); addr = 12'h000;
        repeat (3) @(negedge clk);
        check("R12", rdata, held);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule